// File: doc/BRIEF.md
# Reset and Stop-Recovery Sequencer

This block decides when the processor core and its peripherals may leave reset. It watches five kinds of request: the supply-good level from the power-on and brownout detector, a timeout from the watchdog, an active-low external reset pin, a debug-requested reset bit, and a set of wake pins that matter only in stop mode. Every accepted request starts the same two-part delay. First a counter on the slow watchdog-oscillator clock runs for a fixed number of cycles. Then a counter on the system clock runs for a fixed number of cycles. After that the core reset is released in step with the system clock.

The block separates two kinds of sequence. A full system reset drops both the core-restart reset and the register/peripheral reset. A stop-mode recovery only restarts the core, so general registers and peripheral state are left as they were. A debug-requested reset is a full reset that leaves the debug logic alone. Only a supply failure resets the debug logic. Four status flags record what started the most recent sequence.

Top module: `rstseq_ctrl`

## Requirements
- R1: After supply_ok rises, core_rst_n and regs_rst_n stay low for at least 66 watchdog-clock cycles followed by 16 system-clock cycles. They then rise together on a system-clock edge. The delay never exceeds that figure by more than the synchronizer latency, which is three watchdog-clock cycles plus eight system-clock cycles. Outside a sequence, regs_rst_n is never low while core_rst_n is high.
- R2: A stop-mode recovery holds core_rst_n low for the same two-part delay as R1, and regs_rst_n stays high throughout.
- R3: The reset pin must read low on at least 4 consecutive system-clock samples to start a full reset. A shorter low pulse has no effect.
- R4: If the reset pin is still low when the delay ends, core_rst_n and regs_rst_n stay low until the pin is released. They then rise within a few system-clock cycles.
- R5: While supply_ok is low, every output is held in its reset state: all reset outputs are low, in_stop is low and the status reads POR only. When supply_ok returns, the full delay of R1 runs again.
- R6: The status flags {stat_por, stat_wdt, stat_ext, stat_stop} take the following values. Supply start gives 1000. Pin reset gives 0010. A watchdog reset in normal mode gives 0100. A watchdog timeout in stop mode gives 0101. A wake recovery gives 0001. A debug reset gives 0000. At most one of POR, WDT and EXT is ever set.
- R7: A rising edge on dbg_rst_req in normal mode starts a full reset. dbg_rst_n stays high during it.
- R8: In stop mode, a level change on a wake pin whose wake_en bit is 1 starts a stop-mode recovery. Changes on disabled pins, and any wake change outside stop mode, are ignored.
- R9: A watchdog timeout in stop mode starts a stop-mode recovery whatever the value of wdt_rst_en.
- R10: In normal mode, a watchdog timeout with wdt_rst_en=1 starts a full reset. With wdt_rst_en=0 it produces exactly one wdt_irq pulse, one system clock long, and no reset.
- R11: A one-cycle stop_req in normal mode sets in_stop and leaves core_rst_n high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| wdt_clk | input | 1 | Watchdog oscillator clock |
| supply_ok | input | 1 | Supply above the safe threshold (asynchronous; low resets everything) |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| wdt_timeout | input | 1 | Watchdog timeout level, asynchronous; its rising edge counts |
| wdt_rst_en | input | 1 | Option: a watchdog timeout in normal mode resets rather than interrupts |
| dbg_rst_req | input | 1 | Debug reset control bit, synchronous to sys_clk; its rising edge counts |
| stop_req | input | 1 | Core enters stop mode, one-cycle pulse on sys_clk |
| wake_en | input | 4 | Per-pin wake enable |
| wake_pin | input | 4 | Wake pins, asynchronous |
| core_rst_n | output | 1 | Core restart reset, active low |
| regs_rst_n | output | 1 | Register and peripheral reset, active low, full resets only |
| dbg_rst_n | output | 1 | Debug logic reset, active low, supply failures only |
| in_stop | output | 1 | Device is in stop mode |
| wdt_irq | output | 1 | Watchdog interrupt pulse |
| stat_por | output | 1 | Last sequence came from supply start |
| stat_wdt | output | 1 | Last sequence came from a watchdog timeout |
| stat_ext | output | 1 | Last sequence came from the reset pin |
| stat_stop | output | 1 | Last sequence was a stop-mode recovery |

## Verification
The assertions assume that stop_req and dbg_rst_req are synchronous to sys_clk and that wdt_rst_en changes only while no watchdog timeout is pending. They also assume that the asynchronous inputs hold each level for at least two system-clock cycles, so that each one reaches the sequencer as a clean level. The stimulus meets these assumptions. All inputs change on the falling edge of sys_clk. Watchdog pulses are three cycles long and debug pulses are two cycles long. The option changes only between events, and random events are spaced by whole sequences. Duration checks use a window derived from the cycle counts and the clock ratio, not an exact cycle number, because the crossings between the two clock domains add a variable latency.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [2:0] {
    ST_OSC,
    ST_SYS,
    ST_HOLD,
    ST_RUN,
    ST_STOP,
    ST_DRAIN
  } seq_state_t;

  typedef struct packed {
    logic por;
    logic wdt;
    logic ext;
    logic stop;
  } cause_t;

  function automatic cause_t mk_cause(input logic por, input logic wdt,
                                      input logic ext, input logic stop);
    cause_t c;
    c.por  = por;
    c.wdt  = wdt;
    c.ext  = ext;
    c.stop = stop;
    return c;
  endfunction

  // true when a counter holding v has reached the last step of lim steps
  function automatic logic at_last(input int unsigned v, input int unsigned lim);
    return v == lim - 1;
  endfunction

endpackage

// File: rtl/rstseq_rsync.sv
module rstseq_rsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh <= '0;
    else         sh <= {sh[STAGES-2:0], 1'b1};
  end

  assign rst_n = sh[STAGES-1];
endmodule

// File: rtl/rstseq_bsync.sv
module rstseq_bsync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/rstseq_pin_filt.sv
module rstseq_pin_filt #(
  parameter int MIN    = 4,
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic pin_low,
  output logic pin_hit
);
  localparam int CW = $clog2(MIN + 1);
  logic [CW-1:0] run_len;

  // synchronize the inverted pin so the reset value means "not asserted"
  rstseq_bsync #(.W(1), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(~pin_n), .q(pin_low)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       run_len <= '0;
    else if (!pin_low)                run_len <= '0;
    else if (32'(run_len) != MIN)     run_len <= run_len + 1'b1;
  end

  assign pin_hit = pin_low && rstseq_pkg::at_last(32'(run_len), MIN);
endmodule

// File: rtl/rstseq_osc_cnt.sv
module rstseq_osc_cnt #(
  parameter int CYC    = 66,
  parameter int STAGES = 2
) (
  input  logic wclk,
  input  logic wrst_n,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt;
  logic          run_w;

  rstseq_bsync #(.W(1), .STAGES(STAGES)) u_run_sync (
    .clk(wclk), .rst_n(wrst_n), .d(run), .q(run_w)
  );

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!run_w) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      if (rstseq_pkg::at_last(32'(cnt), CYC)) done <= 1'b1;
      else                                    cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rstseq_wake.sv
module rstseq_wake #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pins,
  input  logic [N-1:0] en,
  input  logic         armed,
  output logic         hit
);
  logic [N-1:0] pin_s, pin_q;

  rstseq_bsync #(.W(N), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins), .q(pin_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= '0;
    else        pin_q <= pin_s;
  end

  assign hit = armed && (|((pin_s ^ pin_q) & en));
endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
  import rstseq_pkg::*;
#(
  parameter int OSC_CYC     = 66,
  parameter int SYS_CYC     = 16,
  parameter int PIN_MIN     = 4,
  parameter int WAKE_N      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              sys_clk,
  input  logic              wdt_clk,
  input  logic              supply_ok,
  input  logic              rst_pin_n,
  input  logic              wdt_timeout,
  input  logic              wdt_rst_en,
  input  logic              dbg_rst_req,
  input  logic              stop_req,
  input  logic [WAKE_N-1:0] wake_en,
  input  logic [WAKE_N-1:0] wake_pin,
  output logic              core_rst_n,
  output logic              regs_rst_n,
  output logic              dbg_rst_n,
  output logic              in_stop,
  output logic              wdt_irq,
  output logic              stat_por,
  output logic              stat_wdt,
  output logic              stat_ext,
  output logic              stat_stop
);
  localparam int SCW = $clog2(SYS_CYC + 1);

  // reset and event wires, named for the checker
  logic srst_n, wrst_n;
  logic osc_done_w, osc_done_s;
  logic wdt_s, wdt_q, wdt_hit;
  logic dbg_q, dbg_hit;
  logic pin_low, pin_hit;
  logic wake_hit;

  seq_state_t     state, state_n;
  logic           seq_full, full_n;
  cause_t         cause, cause_n;
  logic [SCW-1:0] cnt, cnt_n;
  logic           osc_run, core_q, regs_q, stop_q, irq_q, irq_n;

  rstseq_rsync #(.STAGES(SYNC_STAGES)) u_srst (
    .clk(sys_clk), .arst_n(supply_ok), .rst_n(srst_n)
  );
  rstseq_rsync #(.STAGES(SYNC_STAGES)) u_wrst (
    .clk(wdt_clk), .arst_n(supply_ok), .rst_n(wrst_n)
  );

  rstseq_osc_cnt #(.CYC(OSC_CYC), .STAGES(SYNC_STAGES)) u_osc (
    .wclk(wdt_clk), .wrst_n(wrst_n), .run(osc_run), .done(osc_done_w)
  );
  rstseq_bsync #(.W(1), .STAGES(SYNC_STAGES)) u_done_sync (
    .clk(sys_clk), .rst_n(srst_n), .d(osc_done_w), .q(osc_done_s)
  );
  rstseq_bsync #(.W(1), .STAGES(SYNC_STAGES)) u_wdt_sync (
    .clk(sys_clk), .rst_n(srst_n), .d(wdt_timeout), .q(wdt_s)
  );
  rstseq_pin_filt #(.MIN(PIN_MIN), .STAGES(SYNC_STAGES)) u_pin (
    .clk(sys_clk), .rst_n(srst_n), .pin_n(rst_pin_n),
    .pin_low(pin_low), .pin_hit(pin_hit)
  );
  rstseq_wake #(.N(WAKE_N), .STAGES(SYNC_STAGES)) u_wake (
    .clk(sys_clk), .rst_n(srst_n), .pins(wake_pin), .en(wake_en),
    .armed(state == ST_STOP), .hit(wake_hit)
  );

  always_ff @(posedge sys_clk or negedge srst_n) begin
    if (!srst_n) begin
      wdt_q <= 1'b0;
      dbg_q <= 1'b0;
    end else begin
      wdt_q <= wdt_s;
      dbg_q <= dbg_rst_req;
    end
  end

  assign wdt_hit = wdt_s & ~wdt_q;
  assign dbg_hit = dbg_rst_req & ~dbg_q;

  // sequencing decisions
  always_comb begin
    state_n = state;
    full_n  = seq_full;
    cause_n = cause;
    cnt_n   = cnt;
    irq_n   = 1'b0;
    unique case (state)
      ST_DRAIN: if (!osc_done_s) state_n = ST_OSC;
      ST_OSC: begin
        if (osc_done_s) begin
          state_n = ST_SYS;
          cnt_n   = '0;
        end
      end
      ST_SYS: begin
        if (at_last(32'(cnt), SYS_CYC)) state_n = pin_low ? ST_HOLD : ST_RUN;
        else                            cnt_n   = cnt + 1'b1;
      end
      ST_HOLD: if (!pin_low) state_n = ST_RUN;
      ST_RUN: begin
        if (pin_hit) begin
          state_n = ST_DRAIN; full_n = 1'b1; cause_n = mk_cause(1'b0, 1'b0, 1'b1, 1'b0);
        end else if (wdt_hit && wdt_rst_en) begin
          state_n = ST_DRAIN; full_n = 1'b1; cause_n = mk_cause(1'b0, 1'b1, 1'b0, 1'b0);
        end else if (wdt_hit) begin
          irq_n = 1'b1;
        end else if (dbg_hit) begin
          state_n = ST_DRAIN; full_n = 1'b1; cause_n = mk_cause(1'b0, 1'b0, 1'b0, 1'b0);
        end else if (stop_req) begin
          state_n = ST_STOP;
        end
      end
      ST_STOP: begin
        if (pin_hit) begin
          state_n = ST_DRAIN; full_n = 1'b1; cause_n = mk_cause(1'b0, 1'b0, 1'b1, 1'b0);
        end else if (wdt_hit) begin
          state_n = ST_DRAIN; full_n = 1'b0; cause_n = mk_cause(1'b0, 1'b1, 1'b0, 1'b1);
        end else if (wake_hit) begin
          state_n = ST_DRAIN; full_n = 1'b0; cause_n = mk_cause(1'b0, 1'b0, 1'b0, 1'b1);
        end
      end
      default: state_n = ST_DRAIN;
    endcase
  end

  always_ff @(posedge sys_clk or negedge srst_n) begin
    if (!srst_n) begin
      state    <= ST_OSC;
      seq_full <= 1'b1;
      cause    <= mk_cause(1'b1, 1'b0, 1'b0, 1'b0);
      cnt      <= '0;
      osc_run  <= 1'b1;
      core_q   <= 1'b0;
      regs_q   <= 1'b0;
      stop_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      state    <= state_n;
      seq_full <= full_n;
      cause    <= cause_n;
      cnt      <= cnt_n;
      osc_run  <= (state_n == ST_OSC);
      core_q   <= (state_n == ST_RUN) || (state_n == ST_STOP);
      regs_q   <= (state_n == ST_RUN) || (state_n == ST_STOP) || !full_n;
      stop_q   <= (state_n == ST_STOP);
      irq_q    <= irq_n;
    end
  end

  assign core_rst_n = core_q;
  assign regs_rst_n = regs_q;
  assign dbg_rst_n  = srst_n;
  assign in_stop    = stop_q;
  assign wdt_irq    = irq_q;
  assign stat_por   = cause.por;
  assign stat_wdt   = cause.wdt;
  assign stat_ext   = cause.ext;
  assign stat_stop  = cause.stop;
endmodule

// File: rtl/rstseq_ctrl_chk.sv
module rstseq_ctrl_chk (
  input logic sys_clk,
  input logic dbg_rst_n,
  input logic core_rst_n,
  input logic regs_rst_n,
  input logic in_stop,
  input logic wdt_irq,
  input logic stat_por,
  input logic stat_wdt,
  input logic stat_ext,
  input logic stat_stop,
  input logic seq_full,
  input logic pin_low,
  input logic wake_hit
);
  // R1: the register reset is never held while the core runs
  a_r1_regs_follow_core: assert property (@(posedge sys_clk) disable iff (!dbg_rst_n)
    core_rst_n |-> regs_rst_n);

  // R2: a recovery sequence leaves the register reset released
  a_r2_recovery_keeps_regs: assert property (@(posedge sys_clk) disable iff (!dbg_rst_n)
    (!seq_full && !core_rst_n) |-> regs_rst_n);

  // R4: reset cannot be released while the pin reads low
  a_r4_pin_holds_reset: assert property (@(posedge sys_clk) disable iff (!dbg_rst_n)
    (pin_low && !core_rst_n) |=> !core_rst_n);

  // R6: at most one primary cause is flagged
  a_r6_one_cause: assert property (@(posedge sys_clk) disable iff (!dbg_rst_n)
    $countones({stat_por, stat_wdt, stat_ext}) <= 1);

  // R6: stop flag never pairs with supply or pin cause
  a_r6_stop_pairing: assert property (@(posedge sys_clk) disable iff (!dbg_rst_n)
    stat_stop |-> (!stat_por && !stat_ext));

  // R8: an accepted wake leaves stop and starts the sequence
  a_r8_wake_exits_stop: assert property (@(posedge sys_clk) disable iff (!dbg_rst_n)
    (in_stop && wake_hit) |=> (!in_stop && !core_rst_n));

  // R10: the interrupt form of the timeout never comes with a reset
  a_r10_irq_no_reset: assert property (@(posedge sys_clk) disable iff (!dbg_rst_n)
    wdt_irq |-> core_rst_n);
endmodule

bind rstseq_ctrl rstseq_ctrl_chk u_chk (
  .sys_clk   (sys_clk),
  .dbg_rst_n (dbg_rst_n),
  .core_rst_n(core_rst_n),
  .regs_rst_n(regs_rst_n),
  .in_stop   (in_stop),
  .wdt_irq   (wdt_irq),
  .stat_por  (stat_por),
  .stat_wdt  (stat_wdt),
  .stat_ext  (stat_ext),
  .stat_stop (stat_stop),
  .seq_full  (seq_full),
  .pin_low   (pin_low),
  .wake_hit  (wake_hit)
);

// File: tb/rstseq_ctrl_bench.sv
`timescale 1ns/1ps
module rstseq_ctrl_bench;
  localparam int TS   = 4;
  localparam int TW   = 12;
  localparam int OSC  = 66;
  localparam int SYS  = 16;
  localparam int PMIN = 4;
  localparam int NW   = 4;

  logic sys_clk = 1'b0;
  logic wdt_clk = 1'b0;
  always #(TS/2) sys_clk = ~sys_clk;
  always #(TW/2) wdt_clk = ~wdt_clk;

  logic supply_ok, rst_pin_n, wdt_timeout, wdt_rst_en, dbg_rst_req, stop_req;
  logic [NW-1:0] wake_en, wake_pin;
  logic core_rst_n, regs_rst_n, dbg_rst_n, in_stop, wdt_irq;
  logic stat_por, stat_wdt, stat_ext, stat_stop;

  rstseq_ctrl u_rstseq_ctrl (
    .sys_clk(sys_clk), .wdt_clk(wdt_clk), .supply_ok(supply_ok),
    .rst_pin_n(rst_pin_n), .wdt_timeout(wdt_timeout), .wdt_rst_en(wdt_rst_en),
    .dbg_rst_req(dbg_rst_req), .stop_req(stop_req), .wake_en(wake_en),
    .wake_pin(wake_pin), .core_rst_n(core_rst_n), .regs_rst_n(regs_rst_n),
    .dbg_rst_n(dbg_rst_n), .in_stop(in_stop), .wdt_irq(wdt_irq),
    .stat_por(stat_por), .stat_wdt(stat_wdt), .stat_ext(stat_ext),
    .stat_stop(stat_stop)
  );

  int checks = 0;
  int errors = 0;
  int low_cnt = 0;
  int irq_cnt = 0;
  bit regs_low_seen = 0;
  bit dbg_low_seen = 0;

  always @(negedge sys_clk) begin
    if (!core_rst_n) low_cnt++;
    if (!regs_rst_n) regs_low_seen = 1;
    if (!dbg_rst_n)  dbg_low_seen = 1;
    if (wdt_irq)     irq_cnt++;
  end

  function automatic int lo_b();
    return (OSC * TW) / TS + SYS;
  endfunction

  function automatic int hi_b();
    return lo_b() + (3 * TW) / TS + 8;
  endfunction

  // expected {por,wdt,ext,stop}; kind 0 pin, 1 watchdog, 2 debug, 3 wake
  function automatic logic [3:0] exp_stat(input int kind, input bit stopped);
    case (kind)
      0:       return 4'b0010;
      1:       return stopped ? 4'b0101 : 4'b0100;
      2:       return 4'b0000;
      default: return stopped ? 4'b0001 : 4'b0000;
    endcase
  endfunction

  function automatic bit exp_full(input int kind, input bit stopped);
    return (kind == 0) || (kind == 2) || (kind == 1 && !stopped);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge sys_clk);
  endtask

  task automatic arm();
    low_cnt = 0;
    regs_low_seen = 0;
    dbg_low_seen = 0;
  endtask

  function automatic logic [3:0] stat_now();
    return {stat_por, stat_wdt, stat_ext, stat_stop};
  endfunction

  task automatic expect_seq(input string tag, input bit full, input logic [3:0] st);
    int guard = 0;
    while (!(low_cnt > 0 && core_rst_n) && guard < 3000) begin
      @(negedge sys_clk);
      guard++;
    end
    chk(low_cnt >= lo_b() && low_cnt <= hi_b(), {tag, " duration"}, low_cnt, lo_b());
    chk(regs_low_seen == full, {tag, " regs reset"}, int'(regs_low_seen), int'(full));
    chk(stat_now() == st, {tag, " status"}, int'(stat_now()), int'(st));
    chk(regs_rst_n == 1'b1 && in_stop == 1'b0, {tag, " released"}, int'(regs_rst_n), 1);
  endtask

  task automatic expect_quiet(input string tag, input bit stopped);
    cyc(25);
    chk(low_cnt == 0 && core_rst_n == 1'b1, {tag, " no reset"}, low_cnt, 0);
    chk(in_stop == stopped, {tag, " stop state"}, int'(in_stop), int'(stopped));
  endtask

  task automatic do_pin(input int n);
    rst_pin_n = 1'b0;
    cyc(n);
    rst_pin_n = 1'b1;
  endtask

  task automatic do_wdt();
    wdt_timeout = 1'b1;
    cyc(3);
    wdt_timeout = 1'b0;
  endtask

  task automatic do_dbg();
    dbg_rst_req = 1'b1;
    cyc(2);
    dbg_rst_req = 1'b0;
  endtask

  task automatic do_stop();
    stop_req = 1'b1;
    cyc(1);
    stop_req = 1'b0;
    cyc(3);
  endtask

  task automatic do_wake(input int i);
    wake_pin[i] = ~wake_pin[i];
  endtask

  initial begin
    #(TS * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int i0;
    void'($urandom(32'd4711));
    supply_ok = 1'b0; rst_pin_n = 1'b1; wdt_timeout = 1'b0; wdt_rst_en = 1'b0;
    dbg_rst_req = 1'b0; stop_req = 1'b0; wake_en = 4'b0101; wake_pin = '0;
    cyc(5);

    // R5: reset state while supply is low
    chk(core_rst_n == 0 && regs_rst_n == 0 && dbg_rst_n == 0 && in_stop == 0,
        "R5 reset state", int'({core_rst_n, regs_rst_n, dbg_rst_n, in_stop}), 0);
    chk(stat_now() == 4'b1000, "R5 reset status", int'(stat_now()), 8);

    // R1: power-on delay
    arm();
    supply_ok = 1'b1;
    expect_seq("R1 power-on", 1'b1, 4'b1000);

    // R11: stop entry keeps core released
    do_stop();
    chk(in_stop == 1'b1 && core_rst_n == 1'b1, "R11 stop entry", int'(in_stop), 1);

    // R8: disabled wake pin ignored in stop
    arm(); do_wake(1);
    expect_quiet("R8 disabled pin", 1'b1);

    // R8 / R2: enabled pin starts recovery
    arm(); do_wake(0);
    expect_seq("R2 wake recovery", 1'b0, 4'b0001);

    // R8: wake outside stop ignored
    arm(); do_wake(2);
    expect_quiet("R8 wake in run", 1'b0);

    // R3: short pin pulse ignored
    arm(); do_pin(PMIN - 1);
    expect_quiet("R3 short pin", 1'b0);
    chk(stat_now() == 4'b0001, "R3 short pin status", int'(stat_now()), 1);

    // R3: long enough pulse resets
    arm(); do_pin(PMIN + 1);
    expect_seq("R3 pin reset", 1'b1, 4'b0010);

    // R10: interrupt form
    wdt_rst_en = 1'b0;
    arm(); i0 = irq_cnt; do_wdt();
    expect_quiet("R10 wdt irq", 1'b0);
    chk(irq_cnt == i0 + 1, "R10 irq pulses", irq_cnt - i0, 1);

    // R10: reset form
    wdt_rst_en = 1'b1;
    arm(); do_wdt();
    expect_seq("R10 wdt reset", 1'b1, 4'b0100);

    // R9: timeout in stop is a recovery even with interrupt option
    wdt_rst_en = 1'b0;
    do_stop();
    arm(); do_wdt();
    expect_seq("R9 wdt in stop", 1'b0, 4'b0101);

    // R7: debug reset spares debug logic
    arm(); do_dbg();
    expect_seq("R7 debug reset", 1'b1, 4'b0000);
    chk(dbg_low_seen == 0, "R7 debug kept", int'(dbg_low_seen), 0);

    // R4: pin held past the sequence end
    arm();
    rst_pin_n = 1'b0;
    cyc(400);
    chk(core_rst_n == 1'b0 && regs_rst_n == 1'b0, "R4 held low", int'(core_rst_n), 0);
    rst_pin_n = 1'b1;
    begin
      int w = 0;
      while (!core_rst_n && w < 20) begin cyc(1); w++; end
      chk(w <= 6, "R4 release latency", w, 6);
    end
    chk(stat_now() == 4'b0010, "R4 status", int'(stat_now()), 2);

    // R5: brownout
    supply_ok = 1'b0;
    cyc(5);
    chk(dbg_rst_n == 0 && core_rst_n == 0 && in_stop == 0, "R5 brownout hold",
        int'({dbg_rst_n, core_rst_n, in_stop}), 0);
    arm();
    supply_ok = 1'b1;
    expect_seq("R5 brownout restart", 1'b1, 4'b1000);

    // R6: random event mix
    for (int it = 0; it < 12; it++) begin
      bit st;
      bit en;
      bit hit;
      int k;
      st = 1'($urandom % 2);
      en = 1'($urandom % 2);
      k  = int'($urandom % 4);
      wdt_rst_en = en;
      if (st) do_stop();
      arm(); i0 = irq_cnt;
      case (k)
        0: do_pin(PMIN + 1 + int'($urandom % 4));
        1: do_wdt();
        2: do_dbg();
        default: do_wake(($urandom % 2) == 0 ? 0 : 2);
      endcase
      hit = (k == 0) || (k == 1 && (st || en)) || (k == 2 && !st) || (k == 3 && st);
      if (hit) begin
        expect_seq("R6 random", exp_full(k, st), exp_stat(k, st));
      end else begin
        expect_quiet("R6 random quiet", st);
        if (k == 1) chk(irq_cnt == i0 + 1, "R10 random irq", irq_cnt - i0, 1);
        if (st) begin
          arm(); do_wake(0);
          expect_seq("R8 random wake", 1'b0, 4'b0001);
        end
      end
      cyc(5);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule